// File: doc/BRIEF.md
# Load-Use Hazard Cycle Timer

This block sits beside the issue stage of a sixteen-register processor and works out how many clock cycles each issued instruction costs. The issue logic presents one instruction at a time: its unit class, up to two source register indices (each with a valid flag), a load destination index, a base cycle count, and two branch flags (taken, and whether the branch has a delay slot). One clock after the handshake completes, the block reports the cycle cost and a stall flag. It also updates a bank of saturating event counters.

Hazards are tracked with two register masks. While an instruction is being evaluated, a fresh pending mask is built: it is empty unless the instruction is a single-register load, in which case it holds only that load's destination bit. When the instruction is accepted, the pending mask replaces the active hazard mask. Source operands are always compared against the active mask, which holds the loads of the previous instruction only. Every source that matches adds one stall cycle. A taken branch with no delay slot adds one more cycle.

Control is a two-state machine. In `ST_IDLE` the block is ready for issue. The transition *accept* (valid and ready both high) moves it to `ST_REPORT`. That state lasts exactly one cycle: the result is flagged valid and issue is held off. The transition *report_done* returns the machine to `ST_IDLE`.

Top module: `load_hazard_timer`

## Requirements
- R1: `in_ready` is high in `ST_IDLE` and low in `ST_REPORT`. After an accepted issue, `out_valid` is high for exactly the next cycle and then low.
- R2: A single-register load (unit code 2) makes its destination the only hazard for the instruction that follows. Any other accepted instruction leaves the hazard mask empty, so a load result is a hazard only for the instruction immediately after the load.
- R3: Each checked source whose valid flag is set and whose register is in the hazard mask adds one cycle and adds one to the load-stall counter. Two matching sources add two. A source whose valid flag is clear never stalls.
- R4: Exec (code 0) and store (code 3) check both `in_src_a` and `in_src_b`. Branch (code 1) checks only `in_src_a`. Load (code 2) checks only its address source `in_src_b`.
- R5: Multi-load (code 4), multi-store (code 5) and the unused codes 6 and 7 cost exactly their base count, perform no hazard check and record no load destination.
- R6: A taken branch whose `in_has_slot` is clear adds one cycle and adds one to the branch-stall counter. A taken branch with a delay slot, and any untaken branch, add nothing.
- R7: Every branch increments either the taken counter or the untaken counter, depending on `in_taken`. Other units change neither counter.
- R8: `out_cycles` equals the base count plus all added cycles. `out_stall` is high exactly when that sum exceeds the base count. The total counter accumulates every `out_cycles` value.
- R9: Every counter stops at 2^CNT_W-1 and never wraps.
- R10: `clr_counters` zeroes all counters on the next clock edge and takes priority over any increment in that same cycle. It leaves the hazard mask unchanged.
- R11: After reset, `in_ready` is 1, `out_valid` is 0, `out_cycles` is 0, `out_stall` is 0, all counters are 0 and the hazard mask is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_counters | input | 1 | Synchronous clear of all counters |
| in_valid | input | 1 | Instruction presented |
| in_ready | output | 1 | Block can accept an instruction |
| in_unit | input | 3 | Unit class code (0 exec, 1 branch, 2 load, 3 store, 4 multi-load, 5 multi-store) |
| in_src_a | input | IDX_W | First source register |
| in_src_a_vld | input | 1 | First source is used |
| in_src_b | input | IDX_W | Second source / load address register |
| in_src_b_vld | input | 1 | Second source is used |
| in_dst | input | IDX_W | Load destination register |
| in_base | input | BASE_W | Base cycle count |
| in_taken | input | 1 | Branch taken |
| in_has_slot | input | 1 | Branch has a delay slot |
| out_valid | output | 1 | Result valid (one cycle) |
| out_cycles | output | BASE_W+2 | Cycle cost of the last instruction |
| out_stall | output | 1 | Extra cycles were added |
| cnt_total | output | CNT_W | Accumulated cycles |
| cnt_load_stall | output | CNT_W | Load-use stall cycles |
| cnt_branch_stall | output | CNT_W | Branch penalty cycles |
| cnt_taken | output | CNT_W | Taken branches |
| cnt_untaken | output | CNT_W | Untaken branches |

## Verification
The embedded properties watch the handshake shape, the result pulse, the emptying of the mask after non-load instructions, the presence of the load destination bit, counter monotonicity, saturation, and clear priority. They also tie an unstalled result to its base count. These are checked on every cycle. Only the directed scenarios can show the numeric cost of each combination of unit class, source match and branch flags; whether a hazard truly lasts exactly one instruction; and whether the counters hold exact values through saturation and through a clear that coincides with an issue.

// File: rtl/lht_pkg.sv
package lht_pkg;

    typedef enum logic [2:0] {
        U_EXEC    = 3'd0,
        U_BRANCH  = 3'd1,
        U_LOAD    = 3'd2,
        U_STORE   = 3'd3,
        U_MLOAD   = 3'd4,
        U_MSTORE  = 3'd5
    } unit_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } state_e;

    typedef struct packed {
        logic chk_a;
        logic chk_b;
        logic is_branch;
        logic is_load;
    } use_t;

    function automatic use_t decode_unit(input logic [2:0] code);
        use_t u;
        u = '0;
        case (code)
            U_EXEC:   begin u.chk_a = 1'b1; u.chk_b = 1'b1; end
            U_STORE:  begin u.chk_a = 1'b1; u.chk_b = 1'b1; end
            U_BRANCH: begin u.chk_a = 1'b1; u.is_branch = 1'b1; end
            U_LOAD:   begin u.chk_b = 1'b1; u.is_load = 1'b1; end
            default:  u = '0;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/lht_ctrl.sv
module lht_ctrl
    import lht_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic accept,
    output logic out_valid
);

    state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (in_valid) state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state)
            ST_IDLE:   in_ready  = 1'b1;
            ST_REPORT: out_valid = 1'b1;
            default:   ;
        endcase
    end

    assign accept = in_valid && in_ready;

    // R1
    accept_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);
    // R1
    report_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R1
    report_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

endmodule

// File: rtl/lht_hazard.sv
module lht_hazard
    import lht_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int BASE_W = 8,
    localparam int IDX_W = $clog2(NREG),
    localparam int OUT_W = BASE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [2:0]        unit,
    input  logic [IDX_W-1:0]  src_a,
    input  logic              src_a_vld,
    input  logic [IDX_W-1:0]  src_b,
    input  logic              src_b_vld,
    input  logic [IDX_W-1:0]  dst,
    input  logic [BASE_W-1:0] base,
    input  logic              taken,
    input  logic              has_slot,
    output logic [OUT_W-1:0]  out_cycles,
    output logic              out_stall,
    output logic [OUT_W-1:0]  ev_cycles,
    output logic [1:0]        ev_load_stalls,
    output logic              ev_br_stall,
    output logic              ev_taken,
    output logic              ev_untaken
);

    use_t            use_d;
    logic [NREG-1:0] active_mask;
    logic [NREG-1:0] pending_mask;
    logic            hit_a, hit_b;
    logic            stalled;

    always_comb begin
        use_d          = decode_unit(unit);
        hit_a          = use_d.chk_a && src_a_vld && active_mask[src_a];
        hit_b          = use_d.chk_b && src_b_vld && active_mask[src_b];
        ev_load_stalls = {1'b0, hit_a} + {1'b0, hit_b};
        ev_br_stall    = use_d.is_branch && taken && !has_slot;
        ev_taken       = use_d.is_branch && taken;
        ev_untaken     = use_d.is_branch && !taken;
        ev_cycles      = OUT_W'(base) + OUT_W'(ev_load_stalls) + OUT_W'(ev_br_stall);
        stalled        = (ev_load_stalls != 2'd0) || ev_br_stall;
        pending_mask   = '0;
        if (use_d.is_load) pending_mask[dst] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_mask <= '0;
            out_cycles  <= '0;
            out_stall   <= 1'b0;
        end else if (accept) begin
            active_mask <= pending_mask;
            out_cycles  <= ev_cycles;
            out_stall   <= stalled;
        end
    end

    // R2
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !use_d.is_load) |=> (active_mask == '0));
    // R2
    mask_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && use_d.is_load) |=> active_mask[$past(dst)]);
    // R2
    mask_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(active_mask) <= 1);
    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(out_cycles));

endmodule

// File: rtl/lht_sat_counter.sv
module lht_sat_counter #(
    parameter int W     = 32,
    parameter int INC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     value
);

    logic [W:0] sum;

    always_comb sum = {1'b0, value} + (W+1)'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      value <= '0;
        else if (clr)    value <= '0;
        else if (sum[W]) value <= '1;
        else             value <= sum[W-1:0];
    end

    // R10
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value == '0));
    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (&value)) |=> (&value));
    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (value >= $past(value)));

endmodule

// File: rtl/load_hazard_timer.sv
module load_hazard_timer
    import lht_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int BASE_W = 8,
    parameter int CNT_W  = 32,
    localparam int IDX_W = $clog2(NREG),
    localparam int OUT_W = BASE_W + 2,
    localparam int NCNT  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_counters,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_unit,
    input  logic [IDX_W-1:0]  in_src_a,
    input  logic              in_src_a_vld,
    input  logic [IDX_W-1:0]  in_src_b,
    input  logic              in_src_b_vld,
    input  logic [IDX_W-1:0]  in_dst,
    input  logic [BASE_W-1:0] in_base,
    input  logic              in_taken,
    input  logic              in_has_slot,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_cycles,
    output logic              out_stall,
    output logic [CNT_W-1:0]  cnt_total,
    output logic [CNT_W-1:0]  cnt_load_stall,
    output logic [CNT_W-1:0]  cnt_branch_stall,
    output logic [CNT_W-1:0]  cnt_taken,
    output logic [CNT_W-1:0]  cnt_untaken
);

    logic             accept;
    logic [OUT_W-1:0] ev_cycles;
    logic [1:0]       ev_load_stalls;
    logic             ev_br_stall, ev_taken, ev_untaken;
    logic [OUT_W-1:0] inc_arr [NCNT];
    logic [CNT_W-1:0] cnt_arr [NCNT];

    lht_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .accept    (accept),
        .out_valid (out_valid)
    );

    lht_hazard #(.NREG(NREG), .BASE_W(BASE_W)) u_hazard (
        .clk            (clk),
        .rst_n          (rst_n),
        .accept         (accept),
        .unit           (in_unit),
        .src_a          (in_src_a),
        .src_a_vld      (in_src_a_vld),
        .src_b          (in_src_b),
        .src_b_vld      (in_src_b_vld),
        .dst            (in_dst),
        .base           (in_base),
        .taken          (in_taken),
        .has_slot       (in_has_slot),
        .out_cycles     (out_cycles),
        .out_stall      (out_stall),
        .ev_cycles      (ev_cycles),
        .ev_load_stalls (ev_load_stalls),
        .ev_br_stall    (ev_br_stall),
        .ev_taken       (ev_taken),
        .ev_untaken     (ev_untaken)
    );

    always_comb begin
        inc_arr[0] = accept ? ev_cycles : '0;
        inc_arr[1] = accept ? OUT_W'(ev_load_stalls) : '0;
        inc_arr[2] = accept ? OUT_W'(ev_br_stall) : '0;
        inc_arr[3] = accept ? OUT_W'(ev_taken) : '0;
        inc_arr[4] = accept ? OUT_W'(ev_untaken) : '0;
    end

    for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
        lht_sat_counter #(.W(CNT_W), .INC_W(OUT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_counters),
            .inc   (inc_arr[gi]),
            .value (cnt_arr[gi])
        );
    end

    assign cnt_total        = cnt_arr[0];
    assign cnt_load_stall   = cnt_arr[1];
    assign cnt_branch_stall = cnt_arr[2];
    assign cnt_taken        = cnt_arr[3];
    assign cnt_untaken      = cnt_arr[4];

    // R8
    base_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_stall) |-> (out_cycles == OUT_W'($past(in_base))));
    // R8
    stall_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_stall) |-> (out_cycles > OUT_W'($past(in_base))));

endmodule

// File: tb/load_hazard_timer_bench.sv
`timescale 1ns/1ps
module load_hazard_timer_bench;

    localparam int CW   = 10;
    localparam int BW   = 8;
    localparam int OW   = BW + 2;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, clr_counters, in_valid, in_ready;
    logic [2:0]    in_unit;
    logic [3:0]    in_src_a, in_src_b, in_dst;
    logic          in_src_a_vld, in_src_b_vld, in_taken, in_has_slot;
    logic [BW-1:0] in_base;
    logic          out_valid, out_stall;
    logic [OW-1:0] out_cycles;
    logic [CW-1:0] cnt_total, cnt_load_stall, cnt_branch_stall, cnt_taken, cnt_untaken;

    load_hazard_timer #(.NREG(16), .BASE_W(BW), .CNT_W(CW)) u_load_hazard_timer (
        .clk(clk), .rst_n(rst_n), .clr_counters(clr_counters),
        .in_valid(in_valid), .in_ready(in_ready), .in_unit(in_unit),
        .in_src_a(in_src_a), .in_src_a_vld(in_src_a_vld),
        .in_src_b(in_src_b), .in_src_b_vld(in_src_b_vld),
        .in_dst(in_dst), .in_base(in_base), .in_taken(in_taken),
        .in_has_slot(in_has_slot), .out_valid(out_valid),
        .out_cycles(out_cycles), .out_stall(out_stall),
        .cnt_total(cnt_total), .cnt_load_stall(cnt_load_stall),
        .cnt_branch_stall(cnt_branch_stall), .cnt_taken(cnt_taken),
        .cnt_untaken(cnt_untaken)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit summary_done = 1'b0;

    logic [15:0] m_mask;
    int m_tot, m_ls, m_bs, m_tk, m_ut;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sat(int v, int inc);
        return (v + inc > MAXC) ? MAXC : v + inc;
    endfunction

    task automatic chk_counters(string req);
        chk(req, "cnt_total", 32'(cnt_total), m_tot);
        chk(req, "cnt_load_stall", 32'(cnt_load_stall), m_ls);
        chk(req, "cnt_branch_stall", 32'(cnt_branch_stall), m_bs);
        chk(req, "cnt_taken", 32'(cnt_taken), m_tk);
        chk(req, "cnt_untaken", 32'(cnt_untaken), m_ut);
    endtask

    // Issue one instruction and check the result cycle and the return to idle.
    task automatic issue(string req, logic [2:0] u, logic [3:0] a, bit av,
                         logic [3:0] b, bit bv, logic [3:0] d, logic [7:0] base,
                         bit tk, bit sl, bit clr);
        bit chk_a, chk_b, ha, hb, pen, is_br;
        int cyc;
        chk_a = (u == 3'd0) || (u == 3'd3) || (u == 3'd1);
        chk_b = (u == 3'd0) || (u == 3'd3) || (u == 3'd2);
        is_br = (u == 3'd1);
        ha    = chk_a && av && m_mask[a];
        hb    = chk_b && bv && m_mask[b];
        pen   = is_br && tk && !sl;
        cyc   = int'(base) + int'(ha) + int'(hb) + int'(pen);
        if (clr) begin
            m_tot = 0; m_ls = 0; m_bs = 0; m_tk = 0; m_ut = 0;
        end else begin
            m_tot = sat(m_tot, cyc);
            m_ls  = sat(m_ls, int'(ha) + int'(hb));
            m_bs  = sat(m_bs, int'(pen));
            m_tk  = sat(m_tk, int'(is_br && tk));
            m_ut  = sat(m_ut, int'(is_br && !tk));
        end
        m_mask = (u == 3'd2) ? (16'd1 << d) : 16'd0;

        @(negedge clk);
        in_unit = u; in_src_a = a; in_src_a_vld = av; in_src_b = b; in_src_b_vld = bv;
        in_dst = d; in_base = base; in_taken = tk; in_has_slot = sl;
        clr_counters = clr; in_valid = 1'b1;
        chk("R1", "in_ready idle", 32'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; clr_counters = 1'b0;
        chk("R1", "out_valid", 32'(out_valid), 1);
        chk("R1", "in_ready busy", 32'(in_ready), 0);
        chk(req, "out_cycles", 32'(out_cycles), cyc);
        chk(req, "out_stall", 32'(out_stall), int'(cyc != int'(base)));
        chk_counters(req);
        @(posedge clk);
        @(negedge clk);
        chk("R1", "out_valid after", 32'(out_valid), 0);
        chk("R1", "in_ready after", 32'(in_ready), 1);
    endtask

    task automatic t_reset;
        chk("R11", "in_ready", 32'(in_ready), 1);
        chk("R11", "out_valid", 32'(out_valid), 0);
        chk("R11", "out_cycles", 32'(out_cycles), 0);
        chk("R11", "out_stall", 32'(out_stall), 0);
        chk_counters("R11");
        // empty mask: a source on every register stalls nothing
        issue("R11", 3'd0, 4'd0, 1, 4'd15, 1, 4'd0, 8'd1, 0, 0, 0);
    endtask

    task automatic t_load_use;
        issue("R2", 3'd2, 4'd0, 0, 4'd1, 0, 4'd5, 8'd2, 0, 0, 0);
        issue("R3", 3'd0, 4'd5, 1, 4'd0, 0, 4'd0, 8'd1, 0, 0, 0);
        issue("R2", 3'd0, 4'd5, 1, 4'd0, 0, 4'd0, 8'd1, 0, 0, 0);
        issue("R2", 3'd2, 4'd0, 0, 4'd0, 0, 4'd7, 8'd2, 0, 0, 0);
        issue("R3", 3'd2, 4'd0, 0, 4'd7, 1, 4'd9, 8'd2, 0, 0, 0);
        issue("R3", 3'd0, 4'd9, 1, 4'd9, 1, 4'd0, 8'd3, 0, 0, 0);
        issue("R2", 3'd2, 4'd0, 0, 4'd0, 0, 4'd8, 8'd2, 0, 0, 0);
        issue("R2", 3'd0, 4'd7, 1, 4'd9, 1, 4'd0, 8'd1, 0, 0, 0);
    endtask

    task automatic t_invalid;
        issue("R3", 3'd2, 4'd0, 0, 4'd0, 0, 4'd3, 8'd2, 0, 0, 0);
        issue("R3", 3'd0, 4'd3, 0, 4'd3, 0, 4'd0, 8'd1, 0, 0, 0);
        issue("R3", 3'd2, 4'd0, 0, 4'd0, 0, 4'd3, 8'd2, 0, 0, 0);
        issue("R3", 3'd3, 4'd3, 0, 4'd3, 1, 4'd0, 8'd1, 0, 0, 0);
    endtask

    task automatic t_select;
        issue("R4", 3'd2, 4'd0, 0, 4'd0, 0, 4'd4, 8'd2, 0, 0, 0);
        issue("R4", 3'd1, 4'd0, 1, 4'd4, 1, 4'd0, 8'd1, 0, 0, 0);
        issue("R4", 3'd2, 4'd0, 0, 4'd0, 0, 4'd4, 8'd2, 0, 0, 0);
        issue("R4", 3'd2, 4'd4, 1, 4'd1, 1, 4'd2, 8'd2, 0, 0, 0);
        issue("R4", 3'd2, 4'd0, 0, 4'd0, 0, 4'd4, 8'd2, 0, 0, 0);
        issue("R4", 3'd3, 4'd0, 0, 4'd4, 1, 4'd0, 8'd1, 0, 0, 0);
        issue("R4", 3'd2, 4'd0, 0, 4'd0, 0, 4'd4, 8'd2, 0, 0, 0);
        issue("R4", 3'd1, 4'd4, 1, 4'd0, 0, 4'd0, 8'd1, 0, 0, 0);
    endtask

    task automatic t_multi;
        issue("R5", 3'd2, 4'd0, 0, 4'd0, 0, 4'd6, 8'd2, 0, 0, 0);
        issue("R5", 3'd4, 4'd6, 1, 4'd6, 1, 4'd6, 8'd9, 0, 0, 0);
        issue("R5", 3'd0, 4'd6, 1, 4'd6, 1, 4'd0, 8'd1, 0, 0, 0);
        issue("R5", 3'd2, 4'd0, 0, 4'd0, 0, 4'd6, 8'd2, 0, 0, 0);
        issue("R5", 3'd5, 4'd6, 1, 4'd6, 1, 4'd0, 8'd7, 1, 0, 0);
        issue("R5", 3'd2, 4'd0, 0, 4'd0, 0, 4'd6, 8'd2, 0, 0, 0);
        issue("R5", 3'd7, 4'd6, 1, 4'd6, 1, 4'd6, 8'd4, 1, 0, 0);
        issue("R5", 3'd3, 4'd6, 1, 4'd6, 1, 4'd0, 8'd1, 0, 0, 0);
    endtask

    task automatic t_branch;
        issue("R6", 3'd1, 4'd0, 0, 4'd0, 0, 4'd0, 8'd2, 1, 0, 0);
        issue("R6", 3'd1, 4'd0, 0, 4'd0, 0, 4'd0, 8'd2, 1, 1, 0);
        issue("R7", 3'd1, 4'd0, 0, 4'd0, 0, 4'd0, 8'd2, 0, 0, 0);
        issue("R7", 3'd0, 4'd0, 0, 4'd0, 0, 4'd0, 8'd1, 1, 0, 0);
        issue("R6", 3'd2, 4'd0, 0, 4'd0, 0, 4'd11, 8'd2, 0, 0, 0);
        issue("R6", 3'd1, 4'd11, 1, 4'd0, 0, 4'd0, 8'd2, 1, 0, 0);
    endtask

    task automatic t_clear;
        @(negedge clk);
        clr_counters = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr_counters = 1'b0;
        m_tot = 0; m_ls = 0; m_bs = 0; m_tk = 0; m_ut = 0;
        chk_counters("R10");
        issue("R10", 3'd2, 4'd0, 0, 4'd0, 0, 4'd2, 8'd3, 0, 0, 1);
        issue("R10", 3'd0, 4'd2, 1, 4'd0, 0, 4'd0, 8'd1, 0, 0, 0);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 6; i++)
            issue("R8", 3'd0, 4'd0, 0, 4'd0, 0, 4'd0, 8'd255, 0, 0, 0);
        for (int i = 0; i < 520; i++) begin
            issue("R9", 3'd2, 4'd0, 0, 4'd0, 0, 4'd1, 8'd1, 0, 0, 0);
            issue("R9", 3'd0, 4'd1, 1, 4'd1, 1, 4'd0, 8'd1, 0, 0, 0);
        end
        chk("R9", "cnt_load_stall max", 32'(cnt_load_stall), MAXC);
        chk("R9", "cnt_total max", 32'(cnt_total), MAXC);
    endtask

    task automatic finish_run;
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; clr_counters = 1'b0; in_valid = 1'b0; in_unit = 3'd0;
        in_src_a = '0; in_src_b = '0; in_dst = '0; in_src_a_vld = 1'b0;
        in_src_b_vld = 1'b0; in_base = '0; in_taken = 1'b0; in_has_slot = 1'b0;
        m_mask = '0; m_tot = 0; m_ls = 0; m_bs = 0; m_tk = 0; m_ut = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_use();
        t_invalid();
        t_select();
        t_multi();
        t_branch();
        t_clear();
        t_saturate();
        finish_run();
    end

endmodule